// File: doc/BRIEF.md
# SCSI Target Phase and Handshake Assist

This block sits on the target side of a parallel SCSI bus and gives firmware a small byte-wide register window onto the bus control lines. In manual mode, firmware raises and drops each control line with a single register write and polls the synchronized line state to pace the REQ/ACK handshake itself. In auto mode, the block runs a whole REQ/ACK handshake in hardware for each byte, and a 16-bit count bounds the burst.

The direction of an auto burst comes from the I/O bit of the assert register. When I/O is asserted, the target sends, and each accepted write of an outgoing byte starts one handshake. When I/O is released, the target receives. It then raises REQ on its own, captures the initiator's byte on the rising edge of ACK, and holds off the next REQ until firmware has read that byte.

All bus pins on this block use active-high logical polarity, where 1 means the line is asserted. Conversion to open-drain levels happens outside the block. Every incoming line, including the data bus, passes through a two-stage synchronizer before any logic uses it.

Top module: `scsi_target_assist`

## Requirements
- R1: After reset, every drive output and `bus_data_oe` is 0, and a read of the assert register (address 1) or either count register (addresses 4 and 5) returns 0.
- R2: A read of address 0 returns the synchronized bus lines as {BSY, SEL, ACK, ATN, RST, 3'b000}, with BSY in bit 7. A change on an input line shows up in this byte after exactly two rising clock edges.
- R3: A write to address 1 stores a byte that reads back unchanged. When bits 1 and 0 are clear, bits 7..2 drive BSY, SEL, C/D, I/O, MSG and REQ respectively.
- R4: While bit 1 of the assert register is set, `drv_rst` is 1 and every other drive output and `bus_data_oe` is 0. Setting bit 1 also stops any auto handshake and clears the transfer count to 0.
- R5: `bus_data_oe` follows the driven I/O line, and `bus_data_o` carries the last byte accepted at address 3.
- R6: Address 4 holds the high byte and address 5 holds the low byte of the 16-bit transfer count. Both can be written and read back.
- R7: In auto mode with I/O set and a nonzero count, a write to address 3 raises REQ on the following cycle. REQ falls three rising edges after ACK rises. After ACK falls, the count goes down by one.
- R8: In auto mode, the block raises no REQ while the count is 0. A write to address 3 during a handshake is dropped and leaves `bus_data_o` unchanged.
- R9: In auto mode with I/O clear and a nonzero count, the block raises REQ by itself. After each received byte it keeps REQ low until address 2 has been read.
- R10: Address 2 returns the byte that was on the data bus when ACK rose while I/O was clear. This holds in both manual mode and auto mode.
- R11: Clearing bit 0 (auto) in the middle of a handshake releases REQ on the next cycle and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the received-byte flag at address 2) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| bus_bsy_i | input | 1 | BSY line asserted |
| bus_sel_i | input | 1 | SEL line asserted |
| bus_ack_i | input | 1 | ACK line asserted |
| bus_atn_i | input | 1 | ATN line asserted |
| bus_rst_i | input | 1 | RST line asserted |
| bus_data_i | input | 8 | Data bus as seen on the pins |
| drv_bsy | output | 1 | Assert BSY |
| drv_sel | output | 1 | Assert SEL |
| drv_cd | output | 1 | Assert C/D |
| drv_io | output | 1 | Assert I/O |
| drv_msg | output | 1 | Assert MSG |
| drv_req | output | 1 | Assert REQ |
| drv_rst | output | 1 | Assert RST |
| bus_data_o | output | 8 | Outgoing data byte |
| bus_data_oe | output | 1 | Data bus output enable |

## Verification
The hardest state to reach is an auto receive burst that stalls because a captured byte has not been read. To get there, the bench has to complete a full ACK cycle through the synchronizers and then deliberately hold back the read of address 2. The bench plays the initiator: it drives random bytes on the rising edge of ACK, waits several cycles to confirm that REQ stays low, and only then reads the byte and waits for the next REQ. Aborts are handled the same way, with RST or a cleared auto bit written while REQ is still waiting for ACK.

// File: rtl/scsi_assist_pkg.sv
package scsi_assist_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_LINES  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ASSERT = 3'd1;
    localparam logic [ADDR_W-1:0] A_RXDATA = 3'd2;
    localparam logic [ADDR_W-1:0] A_TXDATA = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd5;

    // assert register bit positions
    localparam int B_BSY  = 7;
    localparam int B_SEL  = 6;
    localparam int B_CD   = 5;
    localparam int B_IO   = 4;
    localparam int B_MSG  = 3;
    localparam int B_REQ  = 2;
    localparam int B_RST  = 1;
    localparam int B_AUTO = 0;

    typedef struct packed {
        logic bsy;
        logic sel;
        logic ack;
        logic atn;
        logic rst;
    } bus_in_t;

    localparam int BUS_IN_W = $bits(bus_in_t);

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REQ   = 2'd1,
        HS_ACKLO = 2'd2
    } hs_state_e;

    function automatic logic [BYTE_W-1:0] pack_status(input bus_in_t l);
        return {l.bsy, l.sel, l.ack, l.atn, l.rst, 3'b000};
    endfunction
endpackage

// File: rtl/scsi_in_sync.sv
module scsi_in_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scsi_hs_seq.sv
module scsi_hs_seq
    import scsi_assist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en,
    input  logic              abort,
    input  logic              dir_out,
    input  logic              ack_s,
    input  logic              tx_go,
    input  logic              rx_full,
    input  logic              cnt_wr_hi,
    input  logic              cnt_wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic              seq_req,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt
);
    hs_state_e state;
    logic      start;

    assign start   = (cnt != '0) && (dir_out ? tx_go : !rx_full);
    assign seq_req = (state == HS_REQ);
    assign busy    = (state != HS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            cnt   <= '0;
        end else begin
            if (abort)
                cnt <= '0;
            else if (cnt_wr_hi)
                cnt[CNT_W-1:BYTE_W] <= wdata;
            else if (cnt_wr_lo)
                cnt[BYTE_W-1:0] <= wdata;
            else if (auto_en && state == HS_ACKLO && !ack_s)
                cnt <= cnt - 1'b1;

            if (!auto_en) begin
                state <= HS_IDLE;
            end else begin
                case (state)
                    HS_IDLE:  if (start)  state <= HS_REQ;
                    HS_REQ:   if (ack_s)  state <= HS_ACKLO;
                    HS_ACKLO: if (!ack_s) state <= HS_IDLE;
                    default:              state <= HS_IDLE;
                endcase
            end
        end
    end

    // R7: REQ is only released after ACK was seen, unless auto was dropped
    a_r7_req_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        ($fell(seq_req) && $past(auto_en)) |-> $past(ack_s));

    // R7: the count moves only by register writes, abort or a single decrement
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        ((cnt != $past(cnt)) && !$past(cnt_wr_hi || cnt_wr_lo || abort))
        |-> (cnt == $past(cnt) - 1'b1));

    // R8: no handshake starts with a zero count
    a_r8_no_req_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_req) |-> ($past(cnt) != '0));

    // R9: a receive REQ never starts while a byte is unread
    a_r9_hold_until_read: assert property (@(posedge clk) disable iff (rst)
        ($rose(seq_req) && !$past(dir_out)) |-> !$past(rx_full));
endmodule

// File: rtl/scsi_target_assist.sv
module scsi_target_assist
    import scsi_assist_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              bus_bsy_i,
    input  logic              bus_sel_i,
    input  logic              bus_ack_i,
    input  logic              bus_atn_i,
    input  logic              bus_rst_i,
    input  logic [BYTE_W-1:0] bus_data_i,
    output logic              drv_bsy,
    output logic              drv_sel,
    output logic              drv_cd,
    output logic              drv_io,
    output logic              drv_msg,
    output logic              drv_req,
    output logic              drv_rst,
    output logic [BYTE_W-1:0] bus_data_o,
    output logic              bus_data_oe
);
    localparam int SYNC_W = BYTE_W + BUS_IN_W;

    logic [BYTE_W-1:0] asrt_q, tx_q, rx_q;
    logic              rx_full, ack_d;
    logic [SYNC_W-1:0] sync_in, sync_out;
    bus_in_t           lines_s;
    logic [BYTE_W-1:0] data_s;
    logic              rst_bit, auto_en, io_bit, busy, seq_req;
    logic              wr_asrt, wr_tx, tx_go, rd_rx, ack_rise;
    logic [CNT_W-1:0]  cnt;

    assign sync_in = {bus_data_i, bus_bsy_i, bus_sel_i, bus_ack_i, bus_atn_i, bus_rst_i};

    scsi_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    assign data_s  = sync_out[SYNC_W-1:BUS_IN_W];
    assign lines_s = bus_in_t'(sync_out[BUS_IN_W-1:0]);

    assign rst_bit  = asrt_q[B_RST];
    assign auto_en  = asrt_q[B_AUTO] & ~rst_bit;
    assign io_bit   = asrt_q[B_IO];
    assign wr_asrt  = reg_wr && (reg_addr == A_ASSERT);
    assign wr_tx    = reg_wr && (reg_addr == A_TXDATA);
    assign tx_go    = wr_tx && !(auto_en && busy);
    assign rd_rx    = reg_rd && (reg_addr == A_RXDATA);
    assign ack_rise = lines_s.ack && !ack_d;

    scsi_hs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (auto_en),
        .abort     (rst_bit),
        .dir_out   (io_bit),
        .ack_s     (lines_s.ack),
        .tx_go     (tx_go),
        .rx_full   (rx_full),
        .cnt_wr_hi (reg_wr && (reg_addr == A_CNT_HI)),
        .cnt_wr_lo (reg_wr && (reg_addr == A_CNT_LO)),
        .wdata     (reg_wdata),
        .seq_req   (seq_req),
        .busy      (busy),
        .cnt       (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            asrt_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            rx_full <= 1'b0;
            ack_d   <= 1'b0;
        end else begin
            ack_d <= lines_s.ack;
            if (wr_asrt) asrt_q <= reg_wdata;
            if (tx_go)   tx_q   <= reg_wdata;
            if (ack_rise && !io_bit) begin
                rx_q    <= data_s;
                rx_full <= 1'b1;
            end else if (rd_rx) begin
                rx_full <= 1'b0;
            end
        end
    end

    assign drv_rst     = rst_bit;
    assign drv_bsy     = asrt_q[B_BSY] & ~rst_bit;
    assign drv_sel     = asrt_q[B_SEL] & ~rst_bit;
    assign drv_cd      = asrt_q[B_CD]  & ~rst_bit;
    assign drv_io      = io_bit        & ~rst_bit;
    assign drv_msg     = asrt_q[B_MSG] & ~rst_bit;
    assign drv_req     = ~rst_bit & (asrt_q[B_AUTO] ? seq_req : asrt_q[B_REQ]);
    assign bus_data_oe = drv_io;
    assign bus_data_o  = tx_q;

    always_comb begin
        case (reg_addr)
            A_LINES:  reg_rdata = pack_status(lines_s);
            A_ASSERT: reg_rdata = asrt_q;
            A_RXDATA: reg_rdata = rx_q;
            A_TXDATA: reg_rdata = tx_q;
            A_CNT_HI: reg_rdata = cnt[CNT_W-1:BYTE_W];
            A_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
            default:  reg_rdata = '0;
        endcase
    end

    // R4: bus reset excludes every other driven line and the data bus
    a_r4_reset_alone: assert property (@(posedge clk) disable iff (rst)
        drv_rst |-> !(drv_bsy || drv_sel || drv_cd || drv_io || drv_msg || drv_req || bus_data_oe));

    // R4: a bus reset request leaves no transfer count behind
    a_r4_abort_clears: assert property (@(posedge clk) disable iff (rst)
        $past(drv_rst) |-> (cnt == '0));

    // R10: a captured byte is one the synchronized bus carried the cycle before
    a_r10_capture: assert property (@(posedge clk) disable iff (rst)
        (rx_q != $past(rx_q)) |-> (rx_q == $past(data_s)));
endmodule

// File: tb/scsi_target_assist_tb.sv
module scsi_target_assist_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bsy_i = 0, sel_i = 0, ack_i = 0, atn_i = 0, brst_i = 0;
    logic [7:0] data_i = '0;
    logic       drv_bsy, drv_sel, drv_cd, drv_io, drv_msg, drv_req, drv_rst;
    logic [7:0] data_o;
    logic       data_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_target_assist u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_bsy_i(bsy_i), .bus_sel_i(sel_i), .bus_ack_i(ack_i), .bus_atn_i(atn_i),
        .bus_rst_i(brst_i), .bus_data_i(data_i),
        .drv_bsy(drv_bsy), .drv_sel(drv_sel), .drv_cd(drv_cd), .drv_io(drv_io),
        .drv_msg(drv_msg), .drv_req(drv_req), .drv_rst(drv_rst),
        .bus_data_o(data_o), .bus_data_oe(data_oe)
    );

    function automatic logic [7:0] exp_status(logic b, logic s, logic a, logic t, logic r);
        return {b, s, a, t, r, 3'b000};
    endfunction

    function automatic logic [7:0] exp_drives(logic [7:0] asrt, logic seq_req);
        if (asrt[1]) return 8'b0000_0010;
        return {asrt[7:3], (asrt[0] ? seq_req : asrt[2]), 2'b00};
    endfunction

    function automatic logic [7:0] drives();
        return {drv_bsy, drv_sel, drv_cd, drv_io, drv_msg, drv_req, drv_rst, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_req(input logic lvl, input string req);
        int n = 0;
        while (drv_req !== lvl && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(req, drv_req, lvl);
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        rd(3'd4, h);
        rd(3'd5, l);
        c = {h, l};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] c;
        void'($urandom(32'h5C51));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 drives", drives(), 8'h00);
        chk("R1 oe", data_oe, 1'b0);
        rd(3'd1, v); chk("R1 assert reg", v, 8'h00);
        rd_cnt(c);   chk("R1 count", c, 16'h0);

        // R2: status layout and two-edge synchronizer latency
        for (int k = 0; k < 4; k++) begin
            logic b, s, a, t, r;
            logic [7:0] prev;
            {b, s, a, t, r} = 5'($urandom());
            if (k == 0) {b, s, a, t, r} = 5'b10011;
            @(negedge clk);
            reg_addr = 3'd0;
            #1 prev = reg_rdata;
            {bsy_i, sel_i, ack_i, atn_i, brst_i} = {b, s, a, t, r};
            @(negedge clk);
            #1 chk("R2 one edge unchanged", reg_rdata, prev);
            @(negedge clk);
            #1 chk("R2 status after two edges", reg_rdata, exp_status(b, s, a, t, r));
        end
        {bsy_i, sel_i, ack_i, atn_i, brst_i} = 5'b0;
        repeat (3) @(negedge clk);

        // R3: manual drive of each line, readback
        wr(3'd1, 8'hFC);
        chk("R3 all manual drives", drives(), exp_drives(8'hFC, 1'b0));
        rd(3'd1, v); chk("R3 readback", v, 8'hFC);
        wr(3'd1, 8'h04);
        chk("R3 manual REQ only", drives(), exp_drives(8'h04, 1'b0));

        // R5: data enable follows I/O, data follows last write
        wr(3'd1, 8'h10);
        wr(3'd3, 8'h5A);
        chk("R5 oe with io", data_oe, 1'b1);
        chk("R5 data out", data_o, 8'h5A);
        wr(3'd1, 8'h00);
        chk("R5 oe without io", data_oe, 1'b0);

        // R6: count registers
        wr(3'd4, 8'hA5); wr(3'd5, 8'h3C);
        rd(3'd4, v); chk("R6 count hi", v, 8'hA5);
        rd(3'd5, v); chk("R6 count lo", v, 8'h3C);

        // R10: manual receive capture on ACK rise with io clear
        @(negedge clk); data_i = 8'hC3; ack_i = 1'b1;
        repeat (4) @(negedge clk); ack_i = 1'b0; data_i = 8'h00;
        repeat (4) @(negedge clk);
        rd(3'd2, v); chk("R10 manual capture", v, 8'hC3);

        // R7 / R8 / R5: auto send bursts with random data and counts
        for (int burst = 0; burst < 3; burst++) begin
            int n = 1 + int'($urandom() % 4);
            wr(3'd1, 8'h91);
            wr(3'd4, 8'h00); wr(3'd5, 8'(n));
            for (int i = 0; i < n; i++) begin
                logic [7:0] b = 8'($urandom());
                wr(3'd3, b);
                chk("R7 REQ after tx write", drv_req, 1'b1);
                chk("R5 tx byte on bus", data_o, b);
                chk("R5 oe in send", data_oe, 1'b1);
                if (i == 0) begin
                    wr(3'd3, ~b);
                    chk("R8 busy write dropped", data_o, b);
                end
                ack_i = 1'b1;
                repeat (2) @(negedge clk);
                chk("R7 REQ held two edges", drv_req, 1'b1);
                @(negedge clk);
                chk("R7 REQ falls third edge", drv_req, 1'b0);
                ack_i = 1'b0;
                repeat (4) @(negedge clk);
                rd_cnt(c); chk("R7 count decrement", c, 16'(n - 1 - i));
            end
            wr(3'd3, 8'hEE);
            repeat (3) @(negedge clk);
            chk("R8 no REQ at zero count", drv_req, 1'b0);
        end

        // R9 / R10: auto receive bursts
        for (int burst = 0; burst < 3; burst++) begin
            int n = 1 + int'($urandom() % 4);
            wr(3'd1, 8'h80);
            wr(3'd4, 8'h00); wr(3'd5, 8'(n));
            rd(3'd2, v);
            wr(3'd1, 8'h81);
            for (int i = 0; i < n; i++) begin
                logic [7:0] b = 8'($urandom());
                wait_req(1'b1, "R9 self REQ");
                chk("R9 oe low in receive", data_oe, 1'b0);
                data_i = b; ack_i = 1'b1;
                wait_req(1'b0, "R9 REQ released");
                ack_i = 1'b0;
                repeat (8) @(negedge clk);
                chk("R9 hold until read", drv_req, 1'b0);
                rd(3'd2, v); chk("R10 auto capture", v, b);
            end
            repeat (8) @(negedge clk);
            chk("R8 receive stops at zero", drv_req, 1'b0);
        end

        // R4: RST aborts an auto send and clears count
        wr(3'd1, 8'h91);
        wr(3'd4, 8'h00); wr(3'd5, 8'd3);
        wr(3'd3, 8'h77);
        chk("R4 REQ up before abort", drv_req, 1'b1);
        wr(3'd1, 8'h93);
        chk("R4 only RST driven", drives(), exp_drives(8'h93, 1'b1));
        chk("R4 oe off", data_oe, 1'b0);
        rd_cnt(c); chk("R4 count cleared", c, 16'h0);
        wr(3'd1, 8'h00);

        // R11: clearing auto releases REQ, count kept
        wr(3'd1, 8'h91);
        wr(3'd4, 8'h00); wr(3'd5, 8'd2);
        wr(3'd3, 8'h11);
        chk("R11 REQ up", drv_req, 1'b1);
        wr(3'd1, 8'h90);
        chk("R11 REQ released", drv_req, 1'b0);
        rd_cnt(c); chk("R11 count kept", c, 16'd2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule